// File: doc/BRIEF.md
# Framed Serial Word Transmitter with Embedded Clock Edge

This block turns a parallel payload word into a single serial bit stream. Every word is wrapped in two framing bits of fixed polarity. A high start bit comes before the payload and a low stop bit comes after it. Because the stop bit of one frame is always followed by the start bit of the next, the line has a rising edge at the same position in every frame. A receiver can lock onto that edge without a separate clock lane and without any line code.

The payload width is a parameter. Widths that are not a multiple of eight, such as 10 or 18 bits, work the same way as any other width. One serial bit leaves on each cycle in which the bit-rate enable is high. A new word is taken through a valid/ready handshake only at a frame boundary. If no word is offered at that boundary, the previous word is sent again, so the framing edge never stops.

Top module: `clkEmbedSer`

## Requirements
- R1: After reset, serOut is 0. It stays 0 until the first word is accepted and a frame begins.
- R2: A frame is PAYLOAD_W+2 bit times long, where a bit time is one cycle with bitEn high. Frames follow each other with no gap once the first frame has started.
- R3: Bit position 0 of every frame, the start bit, is 1.
- R4: Bit positions 1 to PAYLOAD_W carry the frame's payload word, least significant bit first.
- R5: Bit position PAYLOAD_W+1, the stop bit, is 0.
- R6: wordReady is high only in a bitEn cycle where the line is idle after reset, or where the stop bit is on serOut. A word is taken when wordValid and wordReady are both high in the same cycle, and wordData is ignored at any other time.
- R7: If no word is taken at a frame boundary after the first frame, the next frame repeats the previous payload.
- R8: serOut changes only on the clock edge that ends a cycle with bitEn high. In all other cycles it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit-rate enable; one serial bit advances per high cycle |
| wordValid | input | 1 | A payload word is offered on wordData |
| wordData | input | PAYLOAD_W | Payload word |
| wordReady | output | 1 | The word offered in this cycle is taken if it is valid |
| serOut | output | 1 | Serial output: start bit, payload LSB first, stop bit |

## Verification
The assertions assume that bitEn is a plain enable with no constraint on its pattern. They also assume that wordData only matters in a cycle where wordValid and wordReady are both high. The bench drives bitEn continuously, at a fixed sub-rate, and at random. It raises wordValid at random and changes wordData on every cycle, including cycles where wordReady is low. This stimulus stays within those assumptions while still probing the ignore rule. Long stretches with wordValid low exercise the repeat path, and an idle period before the first word exercises the low-line rule that holds after reset.

// File: rtl/clkEmbedSerPkg.sv
package clkEmbedSerPkg;
  // Strobes from the frame control to the bit datapath
  typedef struct packed {
    logic takeNew;   // capture wordData into the hold and shift registers
    logic emitStart; // drive the start bit and reload the shifter
    logic emitData;  // drive the next payload bit
    logic emitStop;  // drive the stop bit
  } serStrobeT;
endpackage

// File: rtl/clkEmbedSerCtrl.sv
module clkEmbedSerCtrl
  import clkEmbedSerPkg::*;
#(
  parameter int PAYLOAD_W = 18
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      wordValid,
  output logic      wordReady,
  output serStrobeT strobe
);
  localparam int FRAME_LEN = PAYLOAD_W + 2;
  localparam int POS_W = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] STOP_SRC = POS_W'(FRAME_LEN - 2);

  logic             running;
  logic [POS_W-1:0] bitPos;
  logic             atBoundary;
  logic             frameGo;

  assign atBoundary = !running || (bitPos == LAST_POS);
  assign wordReady  = bitEn && atBoundary;
  assign frameGo    = wordReady && (running || wordValid);

  always_comb begin
    strobe.takeNew   = wordReady && wordValid;
    strobe.emitStart = frameGo;
    strobe.emitData  = bitEn && running && (bitPos < STOP_SRC);
    strobe.emitStop  = bitEn && running && (bitPos == STOP_SRC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      bitPos  <= '0;
    end else if (bitEn) begin
      if (frameGo) begin
        running <= 1'b1;
        bitPos  <= '0;
      end else if (running) begin
        bitPos  <= bitPos + 1'b1;
      end
    end
  end

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitPos <= LAST_POS);

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && running && bitPos == LAST_POS) |=> (bitPos == '0));

  // R8
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(bitPos));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.emitStart, strobe.emitData, strobe.emitStop}));

  // R6
  no_mid_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && bitPos != LAST_POS) |-> !strobe.takeNew);
endmodule

// File: rtl/clkEmbedSerData.sv
module clkEmbedSerData
  import clkEmbedSerPkg::*;
#(
  parameter int PAYLOAD_W = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  serStrobeT            strobe,
  input  logic [PAYLOAD_W-1:0] wordData,
  output logic                 serOut
);
  logic [PAYLOAD_W-1:0] holdReg;
  logic [PAYLOAD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
      serOut   <= 1'b0;
    end else begin
      if (strobe.takeNew) begin
        holdReg  <= wordData;
        shiftReg <= wordData;
      end else if (strobe.emitStart) begin
        shiftReg <= holdReg;
      end else if (strobe.emitData) begin
        shiftReg <= {1'b0, shiftReg[PAYLOAD_W-1:1]};
      end

      if (strobe.emitStart)     serOut <= 1'b1;
      else if (strobe.emitData) serOut <= shiftReg[0];
      else if (strobe.emitStop) serOut <= 1'b0;
    end
  end

  // R3
  start_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitStart |=> serOut);

  // R5
  stop_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitStop |=> !serOut);

  // R8
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.emitStart || strobe.emitData || strobe.emitStop) |=> $stable(serOut));

  // R7
  repeat_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emitStart && !strobe.takeNew) |=> (shiftReg == $past(holdReg)));
endmodule

// File: rtl/clkEmbedSer.sv
module clkEmbedSer
  import clkEmbedSerPkg::*;
#(
  parameter int PAYLOAD_W = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitEn,
  input  logic                 wordValid,
  input  logic [PAYLOAD_W-1:0] wordData,
  output logic                 wordReady,
  output logic                 serOut
);
  serStrobeT strobe;

  clkEmbedSerCtrl #(.PAYLOAD_W(PAYLOAD_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .wordValid (wordValid),
    .wordReady (wordReady),
    .strobe    (strobe)
  );

  clkEmbedSerData #(.PAYLOAD_W(PAYLOAD_W)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordData (wordData),
    .serOut   (serOut)
  );
endmodule

// File: tb/clkEmbedSer_tb_top.sv
`timescale 1ns/1ps
module clkEmbedSer_tb_top;
  localparam int W = 18;
  localparam int FLEN = W + 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bitEn = 1'b0;
  logic         wordValid = 1'b0;
  logic [W-1:0] wordData = '0;
  logic         wordReady;
  logic         serOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkEmbedSer #(.PAYLOAD_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .wordValid(wordValid),
    .wordData(wordData), .wordReady(wordReady), .serOut(serOut)
  );

  // Behavioural reference model
  bit           mStarted = 0;
  int           mPos = 0;
  logic [W-1:0] mWord = '0;
  logic         mOut = 1'b0;
  bit           mRepeat = 0;
  string        mTag = "R1";

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mStarted = 0; mPos = 0; mWord = '0; mOut = 1'b0; mRepeat = 0; mTag = "R1";
    end else if (!bitEn) begin
      mTag = "R8";
    end else if (!mStarted) begin
      if (wordValid) begin
        mStarted = 1; mWord = wordData; mPos = 0; mOut = 1'b1; mRepeat = 0; mTag = "R3";
      end else begin
        mTag = "R1";
      end
    end else if (mPos == FLEN - 1) begin
      mRepeat = !wordValid;
      if (wordValid) mWord = wordData;
      mPos = 0; mOut = 1'b1; mTag = "R2";
    end else begin
      mPos++;
      if (mPos == FLEN - 1) begin
        mOut = 1'b0; mTag = "R5";
      end else begin
        mOut = mWord[mPos-1];
        mTag = mRepeat ? "R7" : "R4";
      end
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    logic expReady;
    if (rstN && !done) begin
      checks++;
      if (serOut !== mOut) begin
        fails++;
        $display("FAIL %s serOut pos=%0d actual=%b expected=%b", mTag, mPos, serOut, mOut);
      end
      expReady = bitEn && (!mStarted || mPos == FLEN - 1);
      checks++;
      if (wordReady !== expReady) begin
        fails++;
        $display("FAIL R6 wordReady actual=%b expected=%b", wordReady, expReady);
      end
    end
  end

  task automatic drive(input int n, input int enMode, input int validPct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      case (enMode)
        0: bitEn = 1'b1;
        1: bitEn = (i % 3) == 0;
        2: bitEn = ($urandom_range(0, 1) == 1);
        default: bitEn = 1'b0;
      endcase
      wordValid = ($urandom_range(0, 99) < validPct);
      wordData  = W'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state: line low before any word
    @(negedge clk);
    checks++;
    if (serOut !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset serOut actual=%b expected=0", serOut);
    end
    drive(50, 0, 0);   // R1 idle with enable, no word
    drive(200, 0, 100);  // back-to-back new words
    drive(300, 1, 50);   // sub-rate enable
    drive(400, 0, 0);    // R7 repeats only
    drive(800, 2, 30);   // random enable
    drive(60, 3, 100);   // R8 enable low, data churn
    drive(1000, 2, 70);
    // mid-run reset then idle
    @(posedge clk); #1 rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    drive(40, 0, 0);
    drive(400, 0, 20);
    @(posedge clk); #1 done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 200000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=<200000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule